// File: doc/BRIEF.md
# Merging Write Buffer with Read Bypass

This block sits between a cache and main memory and holds writes that are waiting to reach memory. Each of its entries holds one block address, a full line of data and a byte-valid mask. Single-word stores from the processor and dirty lines evicted by the cache enter through the same write port. A write whose block address is already held is folded into that entry, and only its enabled bytes change. A write to a new block address takes a free entry. When no entry is free and no entry can absorb the write, the processor is stalled. Entries leave for memory one at a time, oldest first.

Read misses are looked up in the buffer and sent to memory ahead of any pending writes. Draining stops while a read is waiting or in flight. When the memory response arrives, every byte that the buffer holds for that block replaces the stale memory byte. A dirty victim presented in the same cycle as the read miss that evicted it is captured first. The read then goes to memory, and the victim follows as an ordinary drain.

Top module: `merging_write_buffer`

## Requirements
- R1: After synchronous active-low reset the buffer is empty: `wr_stall` and `mem_req_valid` are low, `rd_ready` is high and `rd_resp_valid` is low.
- R2: An accepted write to a block address held by no entry takes a new entry placed after all older entries. It stores the data bytes whose `wr_be` bit is set, where `wr_be[k]` covers byte lane `wr_data[8k+7:8k]`.
- R3: An accepted write whose block address matches a held entry updates only that entry's enabled bytes and sets their mask bits. Other bytes keep their earlier values, and no new entry is used.
- R4: `wr_stall` is high in the same cycle exactly when `wr_valid` is high, all entries are held (counted before any drain in that cycle) and no entry can absorb the write. A stalled write changes nothing.
- R5: A drain presents the oldest entry with `mem_req_we` high, carrying its block address, line data and byte mask. The entry is freed on the cycle `mem_req_ready` is high.
- R6: No drain request is made while `rd_valid` is high or while a read is being issued or awaited.
- R7: A read is accepted when `rd_valid` and `rd_ready` are both high. In the next cycle a memory request with `mem_req_we` low and the accepted address is presented, ahead of all buffered entries, and held until `mem_req_ready`.
- R8: `rd_resp_valid` is high in the same cycle as `mem_rd_valid` while a read is awaited. Each byte of `rd_resp_data` comes from the matching buffer entry if its mask bit is set, and from `mem_rd_data` otherwise. `rd_ready` is high again in the next cycle.
- R9: When a victim write and a read miss arrive in the same cycle, the victim is captured, the read request reaches memory first, and the victim is written later.
- R10: No two held entries ever carry the same block address.
- R11: A write matching the oldest entry in the cycle that entry is accepted by memory is not merged into it. The write takes a new entry instead.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_valid | input | 1 | Write (store or victim) present |
| wr_addr | input | BADDR_W | Block address of the write |
| wr_data | input | LINE_W | Line-wide write data |
| wr_be | input | BE_W | Byte enables, one per byte lane |
| wr_stall | output | 1 | Write cannot be accepted this cycle |
| rd_valid | input | 1 | Read miss lookup request |
| rd_addr | input | BADDR_W | Block address of the read miss |
| rd_ready | output | 1 | Read controller idle, read accepted |
| rd_resp_valid | output | 1 | Read data valid |
| rd_resp_data | output | LINE_W | Memory line merged with buffered bytes |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_we | output | 1 | 1 = drain write, 0 = read |
| mem_req_addr | output | BADDR_W | Block address of the request |
| mem_req_data | output | LINE_W | Drain data |
| mem_req_be | output | BE_W | Drain byte mask (zero for reads) |
| mem_req_ready | input | 1 | Memory takes the request this cycle |
| mem_rd_valid | input | 1 | Memory read data present |
| mem_rd_data | input | LINE_W | Memory read data |

## Verification
A stall and the drain request depend only on stored state and the inputs of the same cycle, so both are due in the cycle of the stimulus. A write or merge shows up in the cycle after the edge that accepts it. A read request appears one cycle after acceptance, and the merged response is due in the very cycle `mem_rd_valid` is driven. The bench changes inputs on the falling edge and samples all outputs 1 ns later, before the next rising edge. It compares them with a cycle-stepped model of the entry queue, the read phase and the memory contents, and then advances that model by what the coming edge commits.

// File: rtl/wbuf_pkg.sv
// Shared types for the merging write buffer.
package wbuf_pkg;
    // Phases of the read-miss controller.
    typedef enum logic [1:0] {
        RD_IDLE  = 2'd0,
        RD_ISSUE = 2'd1,
        RD_WAIT  = 2'd2
    } rd_state_e;
endpackage

// File: rtl/wbuf_store.sv
// Entry store: a ring of address-tagged lines with byte masks.
// Allocates at the tail, frees at the head, merges writes into matching
// entries and answers an address lookup for the read path.
// Assumes N_ENT is a power of two of at least 2 and LINE_W is a multiple of 8.
module wbuf_store #(
    parameter int N_ENT   = 4,
    parameter int BADDR_W = 28,
    parameter int LINE_W  = 128
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_valid,
    input  logic [BADDR_W-1:0] wr_addr,
    input  logic [LINE_W-1:0]  wr_data,
    input  logic [LINE_W/8-1:0] wr_be,
    output logic               wr_stall,
    input  logic               pop,
    output logic               head_valid,
    output logic [BADDR_W-1:0] head_addr,
    output logic [LINE_W-1:0]  head_data,
    output logic [LINE_W/8-1:0] head_be,
    input  logic [BADDR_W-1:0] lk_addr,
    output logic [LINE_W-1:0]  lk_data,
    output logic [LINE_W/8-1:0] lk_be
);
    localparam int BE_W  = LINE_W / 8;
    localparam int PTR_W = $clog2(N_ENT);
    localparam int CNT_W = $clog2(N_ENT + 1);

    logic [N_ENT-1:0]   ent_v_q;
    logic [BADDR_W-1:0] ent_a_q [N_ENT];
    logic [LINE_W-1:0]  ent_d_q [N_ENT];
    logic [BE_W-1:0]    ent_m_q [N_ENT];
    logic [PTR_W-1:0]   head_q, tail_q;
    logic [CNT_W-1:0]   cnt_q;

    logic [N_ENT-1:0]   wr_hit_vec;
    logic [N_ENT-1:0]   lk_vec;
    logic [LINE_W-1:0]  wr_bmask;
    logic               merge, full, alloc;

    // Per-entry address compare for writes (leaving head excluded) and reads.
    for (genvar gi = 0; gi < N_ENT; gi++) begin : g_match
        assign wr_hit_vec[gi] = ent_v_q[gi] && (ent_a_q[gi] == wr_addr)
                                && !(pop && (head_q == PTR_W'(gi)));
        assign lk_vec[gi]     = ent_v_q[gi] && (ent_a_q[gi] == lk_addr);
    end

    // Expand byte enables into a bit mask.
    for (genvar gb = 0; gb < BE_W; gb++) begin : g_bmask
        assign wr_bmask[8*gb +: 8] = {8{wr_be[gb]}};
    end

    assign merge      = |wr_hit_vec;
    assign full       = (cnt_q == CNT_W'(N_ENT));
    assign wr_stall   = wr_valid && !merge && full;
    assign alloc      = wr_valid && !merge && !full;
    assign head_valid = (cnt_q != '0);
    assign head_addr  = ent_a_q[head_q];
    assign head_data  = ent_d_q[head_q];
    assign head_be    = ent_m_q[head_q];

    // Gather the contents of the entry matching the read address.
    always_comb begin
        lk_data = '0;
        lk_be   = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (lk_vec[i]) begin
                lk_data = lk_data | ent_d_q[i];
                lk_be   = lk_be | ent_m_q[i];
            end
        end
    end

    // Entry state: free at head, merge in place, allocate at tail.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_v_q <= '0;
            for (int i = 0; i < N_ENT; i++) begin
                ent_a_q[i] <= '0;
                ent_d_q[i] <= '0;
                ent_m_q[i] <= '0;
            end
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (pop) begin
                ent_v_q[head_q] <= 1'b0;
                head_q          <= head_q + 1'b1;
            end
            for (int i = 0; i < N_ENT; i++) begin
                if (wr_valid && wr_hit_vec[i]) begin
                    ent_d_q[i] <= (ent_d_q[i] & ~wr_bmask) | (wr_data & wr_bmask);
                    ent_m_q[i] <= ent_m_q[i] | wr_be;
                end
            end
            if (alloc) begin
                ent_v_q[tail_q] <= 1'b1;
                ent_a_q[tail_q] <= wr_addr;
                ent_d_q[tail_q] <= wr_data & wr_bmask;
                ent_m_q[tail_q] <= wr_be;
                tail_q          <= tail_q + 1'b1;
            end
            cnt_q <= cnt_q + CNT_W'(alloc) - CNT_W'(pop);
        end
    end

    AST_UNIQUE_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(lk_vec)); // R10
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CNT_W'(N_ENT)); // R4
    AST_STALL_KEEPS_FULL: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stall && !pop |=> cnt_q == CNT_W'(N_ENT)); // R4
    AST_MERGE_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
        wr_valid && merge && !pop |=> $stable(cnt_q)); // R3
    AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> cnt_q != '0); // R5
endmodule

// File: rtl/wbuf_rd_ctrl.sv
// Read-miss controller: accepts one read, issues it to memory, waits for
// the response. Assumes the top gives an issuing read priority on the
// memory request port, so mem_req_ready in RD_ISSUE belongs to the read.
module wbuf_rd_ctrl
    import wbuf_pkg::*;
#(
    parameter int BADDR_W = 28
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               rd_valid,
    input  logic [BADDR_W-1:0] rd_addr,
    input  logic               mem_req_ready,
    input  logic               mem_rd_valid,
    output logic               rd_ready,
    output logic               rd_issue,
    output logic               resp_fire,
    output logic [BADDR_W-1:0] rd_addr_q
);
    rd_state_e state_q;

    assign rd_ready  = (state_q == RD_IDLE);
    assign rd_issue  = (state_q == RD_ISSUE);
    assign resp_fire = (state_q == RD_WAIT) && mem_rd_valid;

    // Phase sequencing and capture of the read address.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= RD_IDLE;
            rd_addr_q <= '0;
        end else begin
            case (state_q)
                RD_IDLE: if (rd_valid) begin
                    state_q   <= RD_ISSUE;
                    rd_addr_q <= rd_addr;
                end
                RD_ISSUE: if (mem_req_ready) state_q <= RD_WAIT;
                RD_WAIT:  if (mem_rd_valid)  state_q <= RD_IDLE;
                default:  state_q <= RD_IDLE;
            endcase
        end
    end

    AST_RD_ISSUE_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready |=> rd_issue && rd_addr_q == $past(rd_addr)); // R7
    AST_RESP_THEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        resp_fire |=> rd_ready); // R8
endmodule

// File: rtl/wbuf_fwd.sv
// Byte-wise forwarding: buffered bytes override the memory line.
// Assumes buf_be is zero when no entry matched.
module wbuf_fwd #(
    parameter int LINE_W = 128
) (
    input  logic                hit,
    input  logic [LINE_W-1:0]   buf_data,
    input  logic [LINE_W/8-1:0] buf_be,
    input  logic [LINE_W-1:0]   mem_data,
    output logic [LINE_W-1:0]   out_data
);
    localparam int BE_W = LINE_W / 8;

    // One selector per byte lane.
    for (genvar gb = 0; gb < BE_W; gb++) begin : g_lane
        assign out_data[8*gb +: 8] = (hit && buf_be[gb]) ? buf_data[8*gb +: 8]
                                                         : mem_data[8*gb +: 8];
    end
endmodule

// File: rtl/merging_write_buffer.sv
// Merging write buffer with read bypass. Writes and victims are held in
// address-tagged entries and drained oldest first. Reads go to memory
// ahead of the drain and get buffered bytes forwarded into the response.
// Assumes memory answers reads in order, one read outstanding at a time.
module merging_write_buffer #(
    parameter int N_ENT   = 4,
    parameter int WORDS   = 4,
    parameter int WORD_W  = 32,
    parameter int BADDR_W = 28
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_valid,
    input  logic [BADDR_W-1:0]              wr_addr,
    input  logic [WORDS*WORD_W-1:0]         wr_data,
    input  logic [WORDS*WORD_W/8-1:0]       wr_be,
    output logic                            wr_stall,
    input  logic                            rd_valid,
    input  logic [BADDR_W-1:0]              rd_addr,
    output logic                            rd_ready,
    output logic                            rd_resp_valid,
    output logic [WORDS*WORD_W-1:0]         rd_resp_data,
    output logic                            mem_req_valid,
    output logic                            mem_req_we,
    output logic [BADDR_W-1:0]              mem_req_addr,
    output logic [WORDS*WORD_W-1:0]         mem_req_data,
    output logic [WORDS*WORD_W/8-1:0]       mem_req_be,
    input  logic                            mem_req_ready,
    input  logic                            mem_rd_valid,
    input  logic [WORDS*WORD_W-1:0]         mem_rd_data
);
    localparam int LINE_W = WORDS * WORD_W;
    localparam int BE_W   = LINE_W / 8;

    logic               head_valid, drain_sel, pop;
    logic [BADDR_W-1:0] head_addr, rd_addr_q;
    logic [LINE_W-1:0]  head_data, lk_data;
    logic [BE_W-1:0]    head_be, lk_be;
    logic               rd_issue, resp_fire;

    // Drain only while the read side is idle and no read is asking.
    assign drain_sel = rd_ready && !rd_valid && head_valid;
    assign pop       = drain_sel && mem_req_ready;

    // Memory request mux: an issuing read wins over the drain.
    assign mem_req_valid = rd_issue || drain_sel;
    assign mem_req_we    = !rd_issue;
    assign mem_req_addr  = rd_issue ? rd_addr_q : head_addr;
    assign mem_req_data  = head_data;
    assign mem_req_be    = rd_issue ? '0 : head_be;
    assign rd_resp_valid = resp_fire;

    wbuf_store #(
        .N_ENT  (N_ENT),
        .BADDR_W(BADDR_W),
        .LINE_W (LINE_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_valid  (wr_valid),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .wr_be     (wr_be),
        .wr_stall  (wr_stall),
        .pop       (pop),
        .head_valid(head_valid),
        .head_addr (head_addr),
        .head_data (head_data),
        .head_be   (head_be),
        .lk_addr   (rd_addr_q),
        .lk_data   (lk_data),
        .lk_be     (lk_be)
    );

    wbuf_rd_ctrl #(
        .BADDR_W(BADDR_W)
    ) u_rd_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .rd_valid     (rd_valid),
        .rd_addr      (rd_addr),
        .mem_req_ready(mem_req_ready),
        .mem_rd_valid (mem_rd_valid),
        .rd_ready     (rd_ready),
        .rd_issue     (rd_issue),
        .resp_fire    (resp_fire),
        .rd_addr_q    (rd_addr_q)
    );

    wbuf_fwd #(
        .LINE_W(LINE_W)
    ) u_fwd (
        .hit     (|lk_be),
        .buf_data(lk_data),
        .buf_be  (lk_be),
        .mem_data(mem_rd_data),
        .out_data(rd_resp_data)
    );

    AST_DRAIN_WHILE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid && mem_req_we |-> rd_ready && !rd_valid); // R6
    AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid && rd_ready |=> mem_req_valid && !mem_req_we); // R9
endmodule

// File: tb/merging_write_buffer_bench.sv
// Cycle-stepped bench: inputs change at the falling edge, outputs are
// compared 1 ns later against a model of queue, read phase and memory.
module merging_write_buffer_bench;
    localparam int N  = 4;
    localparam int LW = 128;
    localparam int BW = 16;
    localparam int AW = 28;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          wr_valid = 0, rd_valid = 0, mem_req_ready = 0, mem_rd_valid = 0;
    logic [AW-1:0] wr_addr = '0, rd_addr = '0;
    logic [LW-1:0] wr_data = '0, mem_rd_data = '0;
    logic [BW-1:0] wr_be = '0;
    logic          wr_stall, rd_ready, rd_resp_valid, mem_req_valid, mem_req_we;
    logic [LW-1:0] rd_resp_data, mem_req_data;
    logic [AW-1:0] mem_req_addr;
    logic [BW-1:0] mem_req_be;

    merging_write_buffer u_merging_write_buffer (
        .clk(clk), .rst_n(rst_n),
        .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_stall(wr_stall),
        .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_ready(rd_ready),
        .rd_resp_valid(rd_resp_valid), .rd_resp_data(rd_resp_data),
        .mem_req_valid(mem_req_valid), .mem_req_we(mem_req_we),
        .mem_req_addr(mem_req_addr), .mem_req_data(mem_req_data),
        .mem_req_be(mem_req_be), .mem_req_ready(mem_req_ready),
        .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
    );

    // Stimulus copies applied at each falling edge.
    logic          s_wv = 0, s_rv = 0, s_rdy = 0, s_mrv = 0;
    logic [AW-1:0] s_wa = '0, s_ra = '0;
    logic [LW-1:0] s_wd = '0;
    logic [BW-1:0] s_be = '0;

    // Model state.
    logic [AW-1:0] q_a[$];
    logic [LW-1:0] q_d[$];
    logic [BW-1:0] q_m[$];
    logic [LW-1:0] mem [16];
    int            ph = 0;
    logic [AW-1:0] r_addr = '0;
    bit            rd_acc = 0;
    int            n_chk = 0, n_bad = 0;

    function automatic logic [LW-1:0] bmask(input logic [BW-1:0] be);
        logic [LW-1:0] m;
        for (int k = 0; k < BW; k++) m[8*k +: 8] = {8{be[k]}};
        return m;
    endfunction

    function automatic logic [LW-1:0] rnd_line();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [LW-1:0] act,
                       input logic [LW-1:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // One clock cycle: drive, compare, then advance the model by the next edge.
    task automatic step();
        bit            exp_drain, exp_issue, exp_resp, pop, stall;
        int            pre, idx, hit;
        logic [LW-1:0] e;
        @(negedge clk);
        wr_valid = s_wv; wr_addr = s_wa; wr_data = s_wd; wr_be = s_be;
        rd_valid = s_rv; rd_addr = s_ra; mem_req_ready = s_rdy;
        mem_rd_valid = s_mrv; mem_rd_data = mem[r_addr[3:0]];
        #1;
        exp_issue = (ph == 1);
        exp_drain = (ph == 0) && !rd_valid && (q_a.size() > 0);
        chk(rd_ready == (ph == 0), "R8 rd_ready", LW'(rd_ready), LW'(ph == 0));
        chk(mem_req_valid == (exp_issue || exp_drain), "R6 mem_req_valid",
            LW'(mem_req_valid), LW'(exp_issue || exp_drain));
        if (exp_issue) begin
            chk(!mem_req_we && mem_req_addr == r_addr, "R7 read request",
                LW'({mem_req_we, mem_req_addr}), LW'({1'b0, r_addr}));
        end else if (exp_drain) begin
            chk(mem_req_we && mem_req_addr == q_a[0], "R5 drain addr",
                LW'({mem_req_we, mem_req_addr}), LW'({1'b1, q_a[0]}));
            chk(mem_req_data == q_d[0] && mem_req_be == q_m[0], "R5 drain data",
                mem_req_data ^ LW'(mem_req_be), q_d[0] ^ LW'(q_m[0]));
        end
        exp_resp = (ph == 2) && mem_rd_valid;
        chk(rd_resp_valid == exp_resp, "R8 rd_resp_valid", LW'(rd_resp_valid), LW'(exp_resp));
        if (exp_resp) begin
            e = mem[r_addr[3:0]];
            hit = -1;
            for (int j = 0; j < q_a.size(); j++) if (q_a[j] == r_addr) hit = j;
            if (hit >= 0) e = (e & ~bmask(q_m[hit])) | (q_d[hit] & bmask(q_m[hit]));
            chk(rd_resp_data == e, "R8 forwarded data", rd_resp_data, e);
        end
        // Advance model: drain, then write, then read phase.
        pop = exp_drain && mem_req_ready;
        pre = q_a.size();
        if (pop) begin
            mem[q_a[0][3:0]] = (mem[q_a[0][3:0]] & ~bmask(q_m[0])) | (q_d[0] & bmask(q_m[0]));
            void'(q_a.pop_front()); void'(q_d.pop_front()); void'(q_m.pop_front());
        end
        if (wr_valid) begin
            idx = -1;
            for (int j = 0; j < q_a.size(); j++) if (q_a[j] == wr_addr) idx = j;
            stall = (idx < 0) && (pre == N);
            chk(wr_stall == stall, "R4 wr_stall", LW'(wr_stall), LW'(stall));
            if (!stall) begin
                if (idx >= 0) begin
                    q_d[idx] = (q_d[idx] & ~bmask(wr_be)) | (wr_data & bmask(wr_be));
                    q_m[idx] = q_m[idx] | wr_be;
                end else begin
                    q_a.push_back(wr_addr);
                    q_d.push_back(wr_data & bmask(wr_be));
                    q_m.push_back(wr_be);
                end
            end
        end else begin
            chk(!wr_stall, "R4 no stall without write", LW'(wr_stall), '0);
        end
        rd_acc = 0;
        case (ph)
            0: if (rd_valid) begin ph = 1; r_addr = rd_addr; rd_acc = 1; end
            1: if (mem_req_ready) ph = 2;
            default: if (mem_rd_valid) ph = 0;
        endcase
    endtask

    task automatic idle_inputs();
        s_wv = 0; s_rv = 0; s_mrv = 0; s_rdy = 0;
    endtask

    // Watchdog: a hung run counts as a failed check.
    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [BW-1:0] be2;
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < 16; i++) mem[i] = rnd_line();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk(!wr_stall && !mem_req_valid && rd_ready && !rd_resp_valid, "R1 reset state",
            LW'({wr_stall, mem_req_valid, rd_ready, rd_resp_valid}), LW'(4'b0010));

        // Fill all entries with memory blocked, then overflow and merge.
        idle_inputs();
        for (int a = 1; a <= N; a++) begin
            s_wv = 1; s_wa = AW'(a); s_wd = rnd_line(); s_be = '1;
            step();
            chk(!wr_stall, "R2 allocate", LW'(wr_stall), '0);
        end
        s_wv = 1; s_wa = 9; s_wd = rnd_line(); s_be = '1;
        step();
        chk(wr_stall, "R4 stall when full", LW'(wr_stall), LW'(1));
        s_wa = 2; s_be = 16'h00F0;
        step();
        chk(!wr_stall, "R3 merge while full", LW'(wr_stall), '0);
        // Read of a buffered block: bypass then forward.
        idle_inputs();
        s_rv = 1; s_ra = 2; s_rdy = 1;
        step();
        s_rv = 0;
        step();
        s_mrv = 1;
        step();
        s_mrv = 0;
        repeat (6) step();
        chk(q_a.size() == 0 && !mem_req_valid, "R5 all drained",
            LW'(mem_req_valid), '0);

        // Victim and read miss in the same cycle.
        s_rdy = 1; s_wv = 1; s_wa = 6; s_wd = rnd_line(); s_be = '1;
        s_rv = 1; s_ra = 7;
        step();
        s_wv = 0; s_rv = 0;
        step();
        chk(mem_req_valid && !mem_req_we && mem_req_addr == 7, "R9 read before victim",
            LW'({mem_req_valid, mem_req_we, mem_req_addr}), LW'({2'b10, AW'(7)}));
        s_mrv = 1;
        step();
        s_mrv = 0;
        step();
        chk(mem_req_valid && mem_req_we && mem_req_addr == 6, "R9 victim written after",
            LW'({mem_req_valid, mem_req_we, mem_req_addr}), LW'({2'b11, AW'(6)}));
        repeat (2) step();

        // Write to the head in the cycle it leaves.
        s_rdy = 0; s_wv = 1; s_wa = 3; s_wd = rnd_line(); s_be = 16'h000F;
        step();
        be2 = 16'hF000;
        s_rdy = 1; s_wd = rnd_line(); s_be = be2;
        step();
        s_wv = 0; s_rdy = 0;
        step();
        chk(mem_req_valid && mem_req_we && mem_req_addr == 3 && mem_req_be == be2,
            "R11 new entry after leaving head", LW'(mem_req_be), LW'(be2));
        s_rdy = 1;
        repeat (3) step();

        // Constrained random traffic.
        for (int it = 0; it < 4000; it++) begin
            s_wv = ($urandom % 2) == 0;
            s_wa = AW'($urandom % 6);
            s_wd = rnd_line();
            if ($urandom % 4 == 0) s_be = '1;
            else s_be = BW'((($urandom % 15) + 1) << (4 * ($urandom % 4)));
            if (!s_rv && ph == 0 && ($urandom % 6 == 0)) begin
                s_rv = 1; s_ra = AW'($urandom % 6);
            end
            s_rdy = ($urandom % 10) < 7;
            s_mrv = (ph == 2) && ($urandom % 2 == 0);
            step();
            if (rd_acc) s_rv = 0;
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule